// File: doc/BRIEF.md
# SDRAM Power-Up Sequencer with Refresh Timer

This block brings one external SDRAM device out of power-up and then keeps time for its refresh. A one-cycle start pulse begins a fixed sequence on the device's command pins. The block first raises clock enable and holds NOP for a power-up wait. It then precharges every bank and issues eight auto-refresh commands. Last, it loads the mode register. Each command is followed by NOP cycles long enough for the device timing that applies to it.

Once the mode-register timing has elapsed, a ready flag goes high and a refresh timer starts. The timer raises a refresh request at a fixed period. A downstream access engine acknowledges the request when it has serviced the refresh. If a new period expires while the old request is still pending, a sticky overrun flag is set.

All delays are counted in controller clock cycles. The timer period is taken from the clock rate: a 64 ms retention window is divided over 4096 rows, the result is rounded up, and a margin of 20 cycles is subtracted.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset, and after reset until start, the outputs are cke=0, the deselect code, ready=0, refReq=0 and refOverrun=0. The command code {csN,rasN,casN,weN} is NOP=0111, precharge-all=0010, auto-refresh=0001, mode-load=0000 and deselect=1111.
- R2: A start pulse sampled at edge e makes cke rise after edge e+1. The command stays NOP for PWRUP_CYCLES cycles, and precharge-all follows in the next cycle, with addr bit 10 high and ba=0.
- R3: Exactly NUM_AREF (8) auto-refresh commands follow. The first comes T_RP (2) cycles after precharge-all, and each later one comes T_RC (7) cycles after the one before it. NOP fills every gap.
- R4: Mode-load issues T_RC cycles after the last auto-refresh, with ba=0. Its address carries burst length 1 (bits 2:0 = 000), sequential burst (bit 3 = 0), CAS latency 3 (bits 6:4 = 011), standard mode (bits 8:7 = 00) and single write (bit 9 = 1), which gives 13'h230.
- R5: ready rises exactly T_MRD (2) cycles after mode-load, with NOP only in between. It never falls until reset, and cke stays high.
- R6: The refresh period is ceil(CLK_KHZ*64/4096)-20 cycles, which is 1668 at 108 MHz. refReq is raised for the first time that many cycles after ready rises, and raised again every period after that.
- R7: refReq stays high until refAck is sampled high. It is low in the next cycle unless a period expires in that same cycle.
- R8: refOverrun is set when a period expires while refReq is high and refAck is low. It stays set until reset.
- R9: A start pulse while the sequence is running, or after ready, has no effect on the command timing.
- R10: After ready, every cycle carries the NOP command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins power-up |
| refAck | input | 1 | Refresh request serviced |
| cke | output | 1 | SDRAM clock enable |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| ready | output | 1 | Initialization complete |
| refReq | output | 1 | Refresh request, held until acknowledged |
| refOverrun | output | 1 | Sticky flag: a refresh period was missed |

## Verification
A wrong wait count or a wrong command-sequencer state shows at the command pins within one cycle of the affected command. The symptom is a command that issues early or late, is missing, or carries the wrong address. Every command cycle from cke rising to ready is compared against a timeline computed from the timing parameters. A wrong refresh counter or a wrong request or overrun state shows at the first timer expiry, at most one period after ready. Checking refReq and refOverrun every cycle under random acknowledge delays exposes such a fault there.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // {csN, rasN, casN, weN}
  typedef enum logic [3:0] {
    CMD_MRS   = 4'b0000,
    CMD_AREF  = 4'b0001,
    CMD_PALL  = 4'b0010,
    CMD_NOP   = 4'b0111,
    CMD_DESEL = 4'b1111
  } sdCmd_t;

  typedef enum logic [2:0] {
    S_IDLE, S_PWRUP, S_PALL, S_AREF, S_MRS, S_GAP, S_DONE
  } seqState_t;

  typedef struct packed {
    logic ckeOn;
    logic issuePall;
    logic issueRef;
    logic issueMrs;
    logic initDone;
  } seqStrobe_t;

  // Mode word: burst length 1, sequential, given CAS latency, standard mode, single write
  function automatic int unsigned makeModeWord(int unsigned casLat);
    return (32'd1 << 9) | ((casLat & 32'd7) << 4);
  endfunction

  function automatic int unsigned maxOf(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int unsigned PWRUP_CYCLES = 10800,
  parameter int unsigned T_RP         = 2,
  parameter int unsigned T_RC         = 7,
  parameter int unsigned T_MRD        = 2,
  parameter int unsigned NUM_AREF     = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output seqStrobe_t stb
);

  localparam int unsigned MAX_WAIT = maxOf(maxOf(PWRUP_CYCLES, T_RC), maxOf(T_RP, T_MRD));
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);
  localparam int unsigned AR_W     = $clog2(NUM_AREF + 1);

  seqState_t        state;
  seqState_t        gapNext;
  logic [CNT_W-1:0] waitCnt;
  logic [AR_W-1:0]  arefLeft;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= S_IDLE;
      gapNext  <= S_IDLE;
      waitCnt  <= '0;
      arefLeft <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_PWRUP;
            waitCnt <= CNT_W'(PWRUP_CYCLES - 1);
          end
        end
        S_PWRUP: begin
          if (waitCnt == '0) state <= S_PALL;
          else               waitCnt <= waitCnt - 1'b1;
        end
        S_PALL: begin
          state    <= S_GAP;
          waitCnt  <= CNT_W'(T_RP - 2);
          gapNext  <= S_AREF;
          arefLeft <= AR_W'(NUM_AREF);
        end
        S_AREF: begin
          arefLeft <= arefLeft - 1'b1;
          state    <= S_GAP;
          waitCnt  <= CNT_W'(T_RC - 2);
          gapNext  <= (arefLeft == AR_W'(1)) ? S_MRS : S_AREF;
        end
        S_MRS: begin
          state   <= S_GAP;
          waitCnt <= CNT_W'(T_MRD - 2);
          gapNext <= S_DONE;
        end
        S_GAP: begin
          if (waitCnt == '0) state <= gapNext;
          else               waitCnt <= waitCnt - 1'b1;
        end
        S_DONE:  state <= S_DONE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.ckeOn     = (state != S_IDLE);
    stb.issuePall = (state == S_PALL);
    stb.issueRef  = (state == S_AREF);
    stb.issueMrs  = (state == S_MRS);
    stb.initDone  = (state == S_DONE);
  end

endmodule

// File: rtl/sdram_init_dp.sv
module sdram_init_dp
  import sdram_init_pkg::*;
#(
  parameter int unsigned ADDR_W     = 13,
  parameter int unsigned BA_W       = 2,
  parameter int unsigned MODE_WORD  = 32'h230,
  parameter int unsigned REF_RELOAD = 1668
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        stb,
  input  logic              refAck,
  output logic              cke,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              refReq,
  output logic              refOverrun
);

  localparam int unsigned     REF_W     = $clog2(REF_RELOAD + 1);
  localparam logic [ADDR_W-1:0] PALL_ADDR = ADDR_W'(1) << 10;
  localparam logic [ADDR_W-1:0] MODE_ADDR = ADDR_W'(MODE_WORD);

  logic [REF_W-1:0] refCnt;
  logic             expire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke   <= 1'b0;
      cmd   <= CMD_DESEL;
      ba    <= '0;
      addr  <= '0;
      ready <= 1'b0;
    end else begin
      cke   <= stb.ckeOn;
      ready <= stb.initDone;
      ba    <= '0;
      addr  <= '0;
      if (stb.issuePall) begin
        cmd  <= CMD_PALL;
        addr <= PALL_ADDR;
      end else if (stb.issueRef) begin
        cmd <= CMD_AREF;
      end else if (stb.issueMrs) begin
        cmd  <= CMD_MRS;
        addr <= MODE_ADDR;
      end else if (stb.ckeOn) begin
        cmd <= CMD_NOP;
      end else begin
        cmd <= CMD_DESEL;
      end
    end
  end

  assign expire = ready && (refCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refCnt     <= REF_W'(REF_RELOAD - 1);
      refReq     <= 1'b0;
      refOverrun <= 1'b0;
    end else begin
      if (!ready || expire) refCnt <= REF_W'(REF_RELOAD - 1);
      else                  refCnt <= refCnt - 1'b1;

      if (expire)      refReq <= 1'b1;
      else if (refAck) refReq <= 1'b0;

      if (expire && refReq && !refAck) refOverrun <= 1'b1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int unsigned CLK_KHZ       = 108000,
  parameter int unsigned PWRUP_CYCLES  = CLK_KHZ / 10,
  parameter int unsigned T_RP          = 2,
  parameter int unsigned T_RC          = 7,
  parameter int unsigned T_MRD         = 2,
  parameter int unsigned NUM_AREF      = 8,
  parameter int unsigned CAS_LAT       = 3,
  parameter int unsigned RETENTION_MS  = 64,
  parameter int unsigned ROW_COUNT     = 4096,
  parameter int unsigned REF_MARGIN    = 20,
  parameter int unsigned ADDR_W        = 13,
  parameter int unsigned BA_W          = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              refAck,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic              refReq,
  output logic              refOverrun
);

  localparam int unsigned REF_RELOAD =
    (CLK_KHZ * RETENTION_MS + ROW_COUNT - 1) / ROW_COUNT - REF_MARGIN;
  localparam int unsigned MODE_WORD = makeModeWord(CAS_LAT);

  seqStrobe_t stb;
  logic [3:0] cmd;

  sdram_init_ctrl #(
    .PWRUP_CYCLES(PWRUP_CYCLES), .T_RP(T_RP), .T_RC(T_RC),
    .T_MRD(T_MRD), .NUM_AREF(NUM_AREF)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stb(stb)
  );

  sdram_init_dp #(
    .ADDR_W(ADDR_W), .BA_W(BA_W), .MODE_WORD(MODE_WORD), .REF_RELOAD(REF_RELOAD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .refAck(refAck),
    .cke(cke), .cmd(cmd), .ba(ba), .addr(addr), .ready(ready),
    .refReq(refReq), .refOverrun(refOverrun)
  );

  assign {csN, rasN, casN, weN} = cmd;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk #(
  parameter int unsigned ADDR_W = 13,
  parameter int unsigned BA_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              refAck,
  input logic              cke,
  input logic              csN,
  input logic              rasN,
  input logic              casN,
  input logic              weN,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              ready,
  input logic              refReq,
  input logic              refOverrun
);

  logic [3:0] cmdBits;
  assign cmdBits = {csN, rasN, casN, weN};

  // R1
  idle_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    !cke |-> (cmdBits == 4'b1111 && !ready));

  // R2
  pall_a10_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits == 4'b0010) |-> (addr[10] && ba == '0));

  // R4
  mode_word_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits == 4'b0000) |-> (addr == ADDR_W'(13'h230) && ba == '0));

  // R5
  mrd_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdBits == 4'b0000) |=> (cmdBits == 4'b0111 && !ready));

  // R5
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> (ready && cke));

  // R6
  req_needs_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> ready);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refAck) |=> refReq);

  // R8
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    refOverrun |=> refOverrun);

  // R10
  ready_nop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> (cmdBits == 4'b0111));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(.ADDR_W(ADDR_W), .BA_W(BA_W)) u_chk (
  .clk(clk), .rstN(rstN), .refAck(refAck), .cke(cke), .csN(csN), .rasN(rasN),
  .casN(casN), .weN(weN), .ba(ba), .addr(addr), .ready(ready),
  .refReq(refReq), .refOverrun(refOverrun)
);

// File: tb/sdram_init_seq_bench.sv
module sdram_init_seq_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PWRUP      = 40;
  localparam int T_RP       = 2;
  localparam int T_RC       = 7;
  localparam int T_MRD      = 2;
  localparam int NAR        = 8;
  localparam int RELOAD     = 1668;
  localparam logic [12:0] MODE = 13'h230;
  localparam logic [3:0] C_NOP = 4'b0111, C_PALL = 4'b0010, C_AREF = 4'b0001,
                         C_MRS = 4'b0000, C_DESEL = 4'b1111;
  localparam int MRS_AT   = PWRUP + T_RP + NAR * T_RC;
  localparam int READY_AT = MRS_AT + T_MRD;

  logic clk = 1'b0;
  logic rstN, start, refAck;
  logic cke, csN, rasN, casN, weN, ready, refReq, refOverrun;
  logic [1:0]  ba;
  logic [12:0] addr;

  int errors = 0;
  int checks = 0;
  int cyc;
  bit expReq, expOvr, ackPrev;

  sdram_init_seq #(.PWRUP_CYCLES(PWRUP)) u_sdram_init_seq (
    .clk(clk), .rstN(rstN), .start(start), .refAck(refAck), .cke(cke),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr),
    .ready(ready), .refReq(refReq), .refOverrun(refOverrun)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] expCmd(int k);
    if (k == PWRUP) return C_PALL;
    for (int i = 0; i < NAR; i++)
      if (k == PWRUP + T_RP + i * T_RC) return C_AREF;
    if (k == MRS_AT) return C_MRS;
    return C_NOP;
  endfunction

  function automatic logic [12:0] expAddr(int k);
    if (k == PWRUP) return 13'h400;
    if (k == MRS_AT) return MODE;
    return 13'h000;
  endfunction

  function automatic string reqOf(int k);
    if (k < PWRUP) return "R2";
    if (k == PWRUP) return "R2";
    if (k < MRS_AT) return "R3";
    if (k == MRS_AT) return "R4";
    return "R5";
  endfunction

  task automatic checkIdle(string req);
    check(cke == 1'b0, req, "cke", cke, 0);
    check({csN, rasN, casN, weN} == C_DESEL, req, "cmd", {csN, rasN, casN, weN}, C_DESEL);
    check(!ready && !refReq && !refOverrun, req, "flags", {ready, refReq, refOverrun}, 0);
  endtask

  // Start pulse, then follow the timeline; stopAt < 0 runs until ready
  task automatic runInit(int stopAt);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(cke == 1'b0, "R2", "cke before rise", cke, 0);
    for (int k = 0; k <= READY_AT; k++) begin
      @(negedge clk);
      if (stopAt >= 0 && k > stopAt) return;
      check(cke == 1'b1, "R2", "cke high", cke, 1);
      check({csN, rasN, casN, weN} == expCmd(k), reqOf(k), "cmd",
            {csN, rasN, casN, weN}, expCmd(k));
      if (expCmd(k) != C_NOP) begin
        check(addr == expAddr(k), reqOf(k), "addr", addr, expAddr(k));
        check(ba == 2'b00, reqOf(k), "ba", ba, 0);
      end
      check(ready == (k >= READY_AT), "R5", "ready", ready, k >= READY_AT);
      // R9: a stray start mid-sequence must not disturb the timeline
      start = (k == 60);
    end
    cyc = 0;
    expReq = 1'b0;
    expOvr = 1'b0;
    ackPrev = 1'b0;
  endtask

  task automatic refPhase(int ncyc, bit withhold);
    int waitFor = 0;
    int target = 0;
    for (int n = 0; n < ncyc; n++) begin
      bit expire;
      bit ack;
      @(negedge clk);
      cyc++;
      expire = (cyc % RELOAD) == 0;
      expOvr = expOvr | (expire && expReq && !ackPrev);
      expReq = expire ? 1'b1 : (ackPrev ? 1'b0 : expReq);
      check(refReq == expReq, expire ? "R6" : "R7", "refReq", refReq, expReq);
      check(refOverrun == expOvr, "R8", "refOverrun", refOverrun, expOvr);
      check({csN, rasN, casN, weN} == C_NOP, "R10", "cmd after ready",
            {csN, rasN, casN, weN}, C_NOP);
      check(ready && cke, "R5", "ready held", {ready, cke}, 3);
      ack = 1'b0;
      if (!withhold) begin
        if (refReq) begin
          if (waitFor == 0) target = $urandom_range(0, 300);
          waitFor++;
          if (waitFor > target) begin
            ack = 1'b1;
            waitFor = 0;
          end
        end else begin
          ack = ($urandom_range(0, 15) == 0);
        end
      end
      refAck = ack;
      ackPrev = ack;
      // R9: start after ready is ignored
      start = (cyc == 10);
    end
    refAck = 1'b0;
    ackPrev = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0;
    start = 1'b0;
    refAck = 1'b0;
    repeat (3) @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    for (int i = 0; i < int'($urandom_range(3, 20)); i++) begin
      @(negedge clk);
      checkIdle("R1");
    end

    runInit(-1);
    refPhase(3 * RELOAD + 50, 1'b0);
    refPhase(2 * RELOAD + 10, 1'b1);
    check(refOverrun == 1'b1, "R8", "overrun set after missed period", refOverrun, 1);

    // Reset in the middle of a fresh sequence, then a full restart
    rstN = 1'b0;
    @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    @(negedge clk);
    runInit(70);
    rstN = 1'b0;
    @(negedge clk);
    checkIdle("R1");
    rstN = 1'b1;
    repeat (int'($urandom_range(1, 9))) @(negedge clk);
    checkIdle("R1");
    runInit(-1);
    refPhase(RELOAD + 400, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule